// File: doc/BRIEF.md
# Dual GPIO Port with Edge Wake-Up

This block holds two 8-bit general-purpose I/O ports, called A and B. Each pin has its own direction bit. A set bit makes the pin an input and a clear bit makes it drive. Software sees the ports through a small register file. The file has single-cycle writes and a combinational read. A read of a port data address returns what the pin is really doing. For an input pin that is the level sampled from the pad. For an output pin it is the value software last wrote.

Port B also watches its pads for transitions. Each pin has a polarity bit that picks a rising or a falling edge, and an enable bit that lets the pin take part. When an enabled pin sees its chosen edge, that pin's sticky flag is set. The wake output is high while any flag is set, so the core can be woken from a low-power state. Software clears a flag by writing a one to its bit.

Top module: `gpio_wake`

## Requirements
- R1: After reset, both direction registers are all ones (every pin an input), both output latches are zero, pad_a_oe and pad_b_oe are zero, the polarity, enable and flag registers are zero, and wake is low.
- R2: Register addresses are 0 A data, 1 B data, 2 A direction, 3 B direction, 4 B edge polarity, 5 B wake enable and 6 B flags. A write happens on a clock edge with reg_wr high. Addresses 2 to 5 read back the stored value. Address 7 reads zero, and writes to it change nothing.
- R3: A direction bit of 1 gives output enable 0 for that pin, and a bit of 0 gives output enable 1. pad_x_out always shows the output latch. Output enables change only after a write to a direction register.
- R4: A read of address 0 or 1 returns the output latch bit for output pins. For input pins it returns the pad level, two clock edges after the pad changes.
- R5: For port B, polarity bit 1 selects a rising edge and 0 selects a falling edge. If a pad changes before clock edge k and the pin is enabled with the matching polarity, the flag bit is set at edge k+2, after the two synchronizer stages. The opposite edge sets nothing.
- R6: A port B pin whose enable bit is 0 never sets its flag. Port A transitions never set any flag.
- R7: A write to address 6 clears every flag bit that has a 1 in the write data. Bits written as 0 keep their value. An edge that is detected in the same cycle as the clear leaves that bit set.
- R8: wake equals the OR of all flag bits. It falls only after a write to address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| pad_a_in | input | 8 | Port A pad levels |
| pad_a_out | output | 8 | Port A output latch |
| pad_a_oe | output | 8 | Port A output enables, 1 = drive |
| pad_b_in | input | 8 | Port B pad levels |
| pad_b_out | output | 8 | Port B output latch |
| pad_b_oe | output | 8 | Port B output enables, 1 = drive |
| wake | output | 1 | Wake request, high while any flag is set |

## Verification
The assertions check several rules on every cycle:
- A flag appears only on an enabled pin.
- The sampled pad level that set a flag matches that pin's polarity bit.
- A flag bit falls only when a write-one clear covers it.
- wake falls and the output enables change only after the matching register write.

Some behaviour only the bench's scenarios can show:
- The exact two-stage delay from a pad change to the data read and to wake.
- The rule that a new edge wins over a clear in the same cycle.
- The mixed read of input and output pins.
- That address 7 has no effect.

These scenarios are checked both against a cycle model driven by random stimulus and against directed cases.

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pad_a_in,
  output logic [W-1:0] pad_a_out,
  output logic [W-1:0] pad_a_oe,
  input  logic [W-1:0] pad_b_in,
  output logic [W-1:0] pad_b_out,
  output logic [W-1:0] pad_b_oe,
  output logic         wake
);
  localparam logic [2:0] AD_A_DATA = 3'd0;
  localparam logic [2:0] AD_B_DATA = 3'd1;
  localparam logic [2:0] AD_A_DIR  = 3'd2;
  localparam logic [2:0] AD_B_DIR  = 3'd3;
  localparam logic [2:0] AD_POL    = 3'd4;
  localparam logic [2:0] AD_EN     = 3'd5;
  localparam logic [2:0] AD_FLAG   = 3'd6;

  logic [W-1:0] a_lat, b_lat, a_dir, b_dir, pol, en, flag;
  logic [W-1:0] a_s1, a_s2, b_s1, b_s2, b_prev;
  logic [W-1:0] hit, clr, a_view, b_view;

  wire wr_at = reg_wr;

  assign hit = en & ((pol & b_s2 & ~b_prev) | (~pol & ~b_s2 & b_prev));
  assign clr = (wr_at && reg_addr == AD_FLAG) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lat  <= '0;
      b_lat  <= '0;
      a_dir  <= '1;
      b_dir  <= '1;
      pol    <= '0;
      en     <= '0;
      flag   <= '0;
      a_s1   <= '0;
      a_s2   <= '0;
      b_s1   <= '0;
      b_s2   <= '0;
      b_prev <= '0;
    end else begin
      a_s1   <= pad_a_in;
      a_s2   <= a_s1;
      b_s1   <= pad_b_in;
      b_s2   <= b_s1;
      b_prev <= b_s2;
      flag   <= (flag & ~clr) | hit;
      if (wr_at) begin
        case (reg_addr)
          AD_A_DATA: a_lat <= reg_wdata;
          AD_B_DATA: b_lat <= reg_wdata;
          AD_A_DIR:  a_dir <= reg_wdata;
          AD_B_DIR:  b_dir <= reg_wdata;
          AD_POL:    pol   <= reg_wdata;
          AD_EN:     en    <= reg_wdata;
          default:   ;
        endcase
      end
    end
  end

  assign a_view = (a_dir & a_s2) | (~a_dir & a_lat);
  assign b_view = (b_dir & b_s2) | (~b_dir & b_lat);

  always_comb begin
    case (reg_addr)
      AD_A_DATA: reg_rdata = a_view;
      AD_B_DATA: reg_rdata = b_view;
      AD_A_DIR:  reg_rdata = a_dir;
      AD_B_DIR:  reg_rdata = b_dir;
      AD_POL:    reg_rdata = pol;
      AD_EN:     reg_rdata = en;
      AD_FLAG:   reg_rdata = flag;
      default:   reg_rdata = '0;
    endcase
  end

  assign pad_a_out = a_lat;
  assign pad_b_out = b_lat;
  assign pad_a_oe  = ~a_dir;
  assign pad_b_oe  = ~b_dir;
  assign wake      = |flag;

  assert_flag_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag)) & ~$past(en)) == '0);

  assert_flag_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag)) & ($past(b_s2) ^ $past(pol))) == '0);

  assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) & ~flag & ~$past(clr)) == '0);

  assert_wake_fall_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake) |-> $past(reg_wr && reg_addr == AD_FLAG));

  assert_oe_a_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_a_oe != $past(pad_a_oe)) |-> $past(reg_wr && reg_addr == AD_A_DIR));

  assert_oe_b_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_b_oe != $past(pad_b_oe)) |-> $past(reg_wr && reg_addr == AD_B_DIR));
endmodule

// File: tb/gpio_wake_tb.sv
module gpio_wake_tb;
  localparam int W = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] pad_a_in = '0, pad_b_in = '0;
  logic [W-1:0] reg_rdata, pad_a_out, pad_a_oe, pad_b_out, pad_b_oe;
  logic wake;

  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_wake #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_a_in(pad_a_in), .pad_a_out(pad_a_out), .pad_a_oe(pad_a_oe),
    .pad_b_in(pad_b_in), .pad_b_out(pad_b_out), .pad_b_oe(pad_b_oe),
    .wake(wake));

  // cycle model built from the requirements
  logic [W-1:0] m_al, m_bl, m_ad, m_bd, m_pol, m_en, m_fl;
  logic [W-1:0] m_a1, m_a2, m_b1, m_b2, m_bp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_al <= '0; m_bl <= '0; m_ad <= '1; m_bd <= '1;
      m_pol <= '0; m_en <= '0; m_fl <= '0;
      m_a1 <= '0; m_a2 <= '0; m_b1 <= '0; m_b2 <= '0; m_bp <= '0;
    end else begin
      logic [W-1:0] h, c;
      h = m_en & ((m_pol & m_b2 & ~m_bp) | (~m_pol & ~m_b2 & m_bp));
      c = (reg_wr && reg_addr == 3'd6) ? reg_wdata : '0;
      m_fl <= (m_fl & ~c) | h;
      m_a1 <= pad_a_in; m_a2 <= m_a1;
      m_b1 <= pad_b_in; m_b2 <= m_b1; m_bp <= m_b2;
      if (reg_wr)
        case (reg_addr)
          3'd0: m_al <= reg_wdata;
          3'd1: m_bl <= reg_wdata;
          3'd2: m_ad <= reg_wdata;
          3'd3: m_bd <= reg_wdata;
          3'd4: m_pol <= reg_wdata;
          3'd5: m_en <= reg_wdata;
          default: ;
        endcase
    end
  end

  function automatic logic [W-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return (m_ad & m_a2) | (~m_ad & m_al);
      3'd1: return (m_bd & m_b2) | (~m_bd & m_bl);
      3'd2: return m_ad;
      3'd3: return m_bd;
      3'd4: return m_pol;
      3'd5: return m_en;
      3'd6: return m_fl;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_check();
    chk("R2", "rdata", reg_rdata, exp_rd(reg_addr));
    chk("R3", "a_oe", pad_a_oe, ~m_ad);
    chk("R3", "b_oe", pad_b_oe, ~m_bd);
    chk("R3", "a_out", pad_a_out, m_al);
    chk("R3", "b_out", pad_b_out, m_bl);
    chk("R8", "wake", {7'd0, wake}, {7'd0, |m_fl});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [W-1:0] exp);
    reg_addr = a;
    #1;
    chk(req, "read", reg_rdata, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(PERIOD * 2);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "a_oe", pad_a_oe, 8'h00);
    chk("R1", "b_oe", pad_b_oe, 8'h00);
    chk("R1", "a_out", pad_a_out, 8'h00);
    chk("R1", "wake", {7'd0, wake}, 8'h00);
    rd(3'd2, "R1", 8'hFF);
    rd(3'd3, "R1", 8'hFF);
    rd(3'd4, "R1", 8'h00);
    rd(3'd5, "R1", 8'h00);
    rd(3'd6, "R1", 8'h00);

    // R2 readback and address 7
    wr(3'd4, 8'h5A); rd(3'd4, "R2", 8'h5A);
    wr(3'd7, 8'hFF); rd(3'd7, "R2", 8'h00);
    rd(3'd4, "R2", 8'h5A);
    chk("R2", "addr7 no effect", pad_a_oe, 8'h00);

    // R3/R4 mixed direction on port A
    wr(3'd0, 8'hC3);
    wr(3'd2, 8'h0F);
    chk("R3", "a_oe", pad_a_oe, 8'hF0);
    chk("R3", "a_out", pad_a_out, 8'hC3);
    pad_a_in = 8'hA5;
    step();
    rd(3'd0, "R4", 8'hC0);
    step();
    rd(3'd0, "R4", 8'hC5);

    // R6 port A edges and disabled B pins set nothing
    wr(3'd5, 8'h00);
    wr(3'd4, 8'hFF);
    pad_a_in = 8'h5A; pad_b_in = 8'hFF;
    repeat (4) step();
    chk("R6", "wake disabled", {7'd0, wake}, 8'h00);
    rd(3'd6, "R6", 8'h00);

    // R5 rising edge timing on B0, falling on B1
    pad_b_in = 8'h00;
    repeat (4) step();
    wr(3'd4, 8'h01);
    wr(3'd5, 8'h03);
    pad_b_in = 8'h01;
    step();
    chk("R5", "edge+1", {7'd0, wake}, 8'h00);
    step();
    chk("R5", "edge+2", {7'd0, wake}, 8'h00);
    step();
    chk("R5", "edge+3", {7'd0, wake}, 8'h01);
    rd(3'd6, "R5", 8'h01);
    pad_b_in = 8'h02;
    repeat (3) step();
    rd(3'd6, "R5 falling B1 wrong polarity", 8'h01);
    pad_b_in = 8'h00;
    repeat (3) step();
    rd(3'd6, "R5 falling B1", 8'h03);

    // R7 write-one clear, zero bits kept
    wr(3'd6, 8'h01);
    rd(3'd6, "R7", 8'h02);
    chk("R8", "wake still", {7'd0, wake}, 8'h01);
    wr(3'd6, 8'h02);
    chk("R8", "wake cleared", {7'd0, wake}, 8'h00);

    // R7 edge in same cycle as clear keeps bit
    pad_b_in = 8'h01;
    step(); step();
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h01;
    step();
    rd(3'd6, "R7 set wins", 8'h01);
    wr(3'd6, 8'hFF);

    // random phase against the cycle model
    for (int i = 0; i < 3000; i++) begin
      reg_wr    = ($urandom % 3) == 0;
      reg_addr  = 3'($urandom);
      reg_wdata = 8'($urandom);
      if (($urandom % 4) == 0) pad_a_in = 8'($urandom);
      if (($urandom % 3) == 0) pad_b_in = pad_b_in ^ 8'($urandom);
      #1;
      model_check();
      @(posedge clk);
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule